// File: doc/BRIEF.md
# Shifted Multi-Table Hash Candidate Store

This block remembers, for every hash bucket, the most recent byte positions at which a given four-byte string began. It is built for a match finder that handles one position per cycle. Each incoming item carries the four bytes starting at the current position and the position itself. The block folds the bytes into a bucket index. It reads all `NTAB` tables at that index in one access and returns every stored candidate together, with no chain to walk. It then writes the bucket back shifted by one: each table takes the entry from the table one level shallower, table 0 takes the current position, and the deepest entry is discarded.

Input and output are valid/ready streams with one register stage between them. An item is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is presented on `out_valid` from the next cycle on. While `out_valid` is high and `out_ready` is low, every output is held and `in_ready` is low, so back-pressure stalls the input directly. Invalid candidate slots have an undefined position field.

Top module: `hash_cand_store`

## Requirements
- R1: The bucket index is computed as follows. Let byte k be `in_bytes[8k+7:8k]`, and let `f = in_bytes[15:0] ^ in_bytes[31:16]`. The 16-bit value f is zero-extended and multiplied by 0x9E3779B1, keeping the low 32 bits of the product. The index is the top `IDX_W` bits of that product. It is reported on `out_idx`.
- R2: Candidate slot k is `out_cand[k*POS_W +: POS_W]`, with valid bit `out_cand_vld[k]`. Slot k holds the (k+1)-th most recent earlier accepted position that had the same index.
- R3: The candidates reflect the bucket before the current item's own insertion, so an item never sees its own position.
- R4: After more than `NTAB` hits on one index, only the latest `NTAB` earlier positions are returned and the oldest is dropped.
- R5: Reset empties every bucket. An index's first hit after reset reports all valid bits 0, and valid bits always fill from slot 0 upward with no gaps.
- R6: Items with the same index on consecutive cycles see each other's updates exactly as if they had been spaced apart.
- R7: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. An accepted item appears on the output on the next cycle. A stalled output holds all its values.
- R8: `out_pos` returns the accepted item's position.
- R9: Cycles without an accepted item leave the buckets unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input item valid |
| in_ready | output | 1 | Block can accept an item |
| in_bytes | input | 32 | Four bytes starting at the position, byte 0 in the low bits |
| in_pos | input | POS_W | Byte position of the item |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_pos | output | POS_W | Position of the item |
| out_idx | output | IDX_W | Bucket index of the item |
| out_cand | output | NTAB*POS_W | Candidate positions, slot 0 newest |
| out_cand_vld | output | NTAB | Per-slot candidate valid |

## Verification
The hardest case is a same-index item accepted in the cycle when the previous item's write-back is still pending, because that is the only time the forwarding path is used. The stimulus streams runs of one fixed four-byte word on back-to-back cycles with the consumer always ready. The runs are long enough to overflow the tables, and they are repeated under an irregular ready pattern and with idle gaps. A scoreboard holds a model of every bucket and checks each result.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
  localparam logic [31:0] HCS_MULT = 32'h9E3779B1;

  function automatic logic [31:0] hcs_mix(input logic [31:0] win);
    logic [15:0] fold;
    fold = win[15:0] ^ win[31:16];
    return {16'b0, fold} * HCS_MULT;
  endfunction
endpackage

// File: rtl/hcs_hash.sv
module hcs_hash #(
  parameter int IDX_W = 10
) (
  input  logic [31:0]      win,
  output logic [IDX_W-1:0] idx
);
  logic [31:0] mixed;
  always_comb begin
    mixed = hcs_pkg::hcs_mix(win);
    idx   = mixed[31 -: IDX_W];
  end
endmodule

// File: rtl/hcs_table.sv
module hcs_table #(
  parameter int POS_W = 16,
  parameter int DEPTH = 1024,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             byp_en,
  input  logic             byp_vld,
  input  logic [POS_W-1:0] byp_pos,
  output logic             q_vld,
  output logic [POS_W-1:0] q_pos,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_vld,
  input  logic [POS_W-1:0] wr_pos
);
  logic [POS_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] vbits;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_pos;
  end

  always_ff @(posedge clk) begin
    if (rst)        vbits <= '0;
    else if (wr_en) vbits[wr_idx] <= wr_vld;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_vld <= 1'b0;
      q_pos <= '0;
    end else if (rd_en) begin
      if (byp_en) begin
        q_vld <= byp_vld;
        q_pos <= byp_pos;
      end else begin
        q_vld <= vbits[rd_idx];
        q_pos <= mem[rd_idx];
      end
    end
  end
endmodule

// File: rtl/hash_cand_store.sv
module hash_cand_store #(
  parameter int POS_W = 16,
  parameter int NTAB  = 4,
  parameter int DEPTH = 1024,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [31:0]           in_bytes,
  input  logic [POS_W-1:0]      in_pos,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [POS_W-1:0]      out_pos,
  output logic [IDX_W-1:0]      out_idx,
  output logic [NTAB*POS_W-1:0] out_cand,
  output logic [NTAB-1:0]       out_cand_vld
);
  logic             fire;
  logic [IDX_W-1:0] idx;
  logic             s_valid;
  logic [POS_W-1:0] s_pos;
  logic [IDX_W-1:0] s_idx;
  logic             wr_pend;
  logic             byp;
  logic [POS_W-1:0] c_pos [NTAB];
  logic [NTAB-1:0]  c_vld;
  logic [POS_W-1:0] w_pos [NTAB];
  logic [NTAB-1:0]  w_vld;

  assign in_ready = !s_valid || out_ready;
  assign fire     = in_valid && in_ready;
  assign byp      = fire && wr_pend && (idx == s_idx);

  hcs_hash #(.IDX_W(IDX_W)) u_hash (.win(in_bytes), .idx(idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      s_valid <= 1'b0;
      wr_pend <= 1'b0;
      s_pos   <= '0;
      s_idx   <= '0;
    end else begin
      wr_pend <= fire;
      if (in_ready) s_valid <= in_valid;
      if (fire) begin
        s_pos <= in_pos;
        s_idx <= idx;
      end
    end
  end

  for (genvar k = 0; k < NTAB; k++) begin : g_tab
    if (k == 0) begin : g_head
      assign w_pos[k] = s_pos;
      assign w_vld[k] = 1'b1;
    end else begin : g_deep
      assign w_pos[k] = c_pos[k-1];
      assign w_vld[k] = c_vld[k-1];
    end

    hcs_table #(.POS_W(POS_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_tab (
      .clk    (clk),
      .rst    (rst),
      .rd_en  (fire),
      .rd_idx (idx),
      .byp_en (byp),
      .byp_vld(w_vld[k]),
      .byp_pos(w_pos[k]),
      .q_vld  (c_vld[k]),
      .q_pos  (c_pos[k]),
      .wr_en  (wr_pend),
      .wr_idx (s_idx),
      .wr_vld (w_vld[k]),
      .wr_pos (w_pos[k])
    );

    assign out_cand[k*POS_W +: POS_W] = c_pos[k];
  end

  assign out_valid    = s_valid;
  assign out_pos      = s_pos;
  assign out_idx      = s_idx;
  assign out_cand_vld = c_vld;
endmodule

// File: rtl/hcs_checker.sv
module hcs_checker #(
  parameter int POS_W = 16,
  parameter int NTAB  = 4,
  parameter int IDX_W = 10
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [POS_W-1:0]      out_pos,
  input logic [IDX_W-1:0]      out_idx,
  input logic [NTAB*POS_W-1:0] out_cand,
  input logic [NTAB-1:0]       out_cand_vld
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_cand) && $stable(out_cand_vld)
      && $stable(out_pos) && $stable(out_idx)); // R7

  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid); // R7

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R7

  AST_NEWEST_FWD: assert property (@(posedge clk) disable iff (rst)
    $past(out_valid && out_ready) && out_valid && out_idx == $past(out_idx)
      |-> out_cand_vld[0] && out_cand[POS_W-1:0] == $past(out_pos)); // R6

  for (genvar k = 1; k < NTAB; k++) begin : g_k
    AST_FILL_ORDER: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_cand_vld[k] |-> out_cand_vld[k-1]); // R5

    AST_SHIFT_FWD: assert property (@(posedge clk) disable iff (rst)
      $past(out_valid && out_ready) && out_valid && out_idx == $past(out_idx)
        |-> out_cand_vld[k] == $past(out_cand_vld[k-1])
          && (!out_cand_vld[k] || out_cand[k*POS_W +: POS_W] == $past(out_cand[(k-1)*POS_W +: POS_W]))); // R4
  end
endmodule

bind hash_cand_store hcs_checker #(.POS_W(POS_W), .NTAB(NTAB), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_pos(out_pos), .out_idx(out_idx),
  .out_cand(out_cand), .out_cand_vld(out_cand_vld)
);

// File: tb/hash_cand_store_bench.sv
module hash_cand_store_bench;
  localparam int POS_W = 16;
  localparam int NTAB  = 4;
  localparam int DEPTH = 1024;
  localparam int IDX_W = 10;

  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0;
  logic in_ready;
  logic [31:0] in_bytes = '0;
  logic [POS_W-1:0] in_pos = '0;
  logic out_valid;
  logic out_ready = 1;
  logic [POS_W-1:0] out_pos;
  logic [IDX_W-1:0] out_idx;
  logic [NTAB*POS_W-1:0] out_cand;
  logic [NTAB-1:0] out_cand_vld;

  int n_run = 0;
  int n_fail = 0;
  int rmode = 0;
  string tag = "R2";

  bit [POS_W-1:0] m_pos [NTAB][DEPTH];
  bit             m_vld [NTAB][DEPTH];

  logic [POS_W-1:0]      q_pos  [$];
  logic [IDX_W-1:0]      q_idx  [$];
  logic [NTAB*POS_W-1:0] q_cand [$];
  logic [NTAB-1:0]       q_cv   [$];
  string                 q_tag  [$];

  always #5 clk = ~clk;

  hash_cand_store #(.POS_W(POS_W), .NTAB(NTAB), .DEPTH(DEPTH)) u_hash_cand_store (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_bytes(in_bytes),
    .in_pos(in_pos), .out_valid(out_valid), .out_ready(out_ready), .out_pos(out_pos),
    .out_idx(out_idx), .out_cand(out_cand), .out_cand_vld(out_cand_vld)
  );

  function automatic logic [IDX_W-1:0] ref_idx(input logic [31:0] w);
    logic [31:0] p;
    p = {16'b0, w[15:0] ^ w[31:16]} * 32'h9E3779B1;
    return p[31:22];
  endfunction

  task automatic model_clear();
    for (int t = 0; t < NTAB; t++)
      for (int d = 0; d < DEPTH; d++) m_vld[t][d] = 0;
  endtask

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // driver: call at a negedge, returns at a negedge with in_valid still high
  task automatic send(input logic [31:0] w, input logic [POS_W-1:0] p);
    logic [IDX_W-1:0] ix;
    logic [NTAB*POS_W-1:0] c;
    logic [NTAB-1:0] cv;
    in_valid = 1; in_bytes = w; in_pos = p;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    ix = ref_idx(w);
    for (int k = 0; k < NTAB; k++) begin
      c[k*POS_W +: POS_W] = m_pos[k][ix];
      cv[k] = m_vld[k][ix];
    end
    for (int k = NTAB-1; k > 0; k--) begin
      m_pos[k][ix] = m_pos[k-1][ix];
      m_vld[k][ix] = m_vld[k-1][ix];
    end
    m_pos[0][ix] = p; m_vld[0][ix] = 1;
    q_pos.push_back(p); q_idx.push_back(ix); q_cand.push_back(c); q_cv.push_back(cv);
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    in_valid = 0;
    while (q_pos.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor
  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      case (rmode)
        0: out_ready = 1;
        1: out_ready = (cyc % 3 != 0) && (cyc % 7 != 2);
        default: out_ready = 0;
      endcase
      #2;
      if (!rst && out_valid && out_ready) begin
        if (q_pos.size() == 0) begin
          check(0, "R7 unexpected output", 64'(out_pos), 64'h0);
        end else begin
          string tg;
          logic [POS_W-1:0] ep;
          logic [IDX_W-1:0] ei;
          logic [NTAB*POS_W-1:0] ec;
          logic [NTAB-1:0] ecv;
          bit ok;
          tg = q_tag.pop_front(); ep = q_pos.pop_front(); ei = q_idx.pop_front();
          ec = q_cand.pop_front(); ecv = q_cv.pop_front();
          check(out_pos == ep, {tg, " R8 position"}, 64'(out_pos), 64'(ep));
          check(out_idx == ei, {tg, " R1 index"}, 64'(out_idx), 64'(ei));
          ok = (out_cand_vld == ecv);
          for (int k = 0; k < NTAB; k++)
            if (ecv[k] && out_cand[k*POS_W +: POS_W] != ec[k*POS_W +: POS_W]) ok = 0;
          check(ok, {tg, " R2 R3 candidates"}, {out_cand, 60'(0)} | 64'(out_cand_vld),
                {ec, 60'(0)} | 64'(ecv));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst = 0;
    #3;
    check(out_valid == 0, "R5 reset out_valid", 64'(out_valid), 0);
    check(in_ready == 1, "R7 reset in_ready", 64'(in_ready), 1);
    @(negedge clk);

    // R6 / R4: one word back-to-back, overflowing the tables
    tag = "R6";
    for (int i = 0; i < 7; i++) send(32'h64636261, POS_W'(10 + i));
    tag = "R4";
    send(32'h11223344, 16'd100);
    send(32'h64636261, 16'd17);
    drain();

    // R7: irregular back-pressure
    rmode = 1; tag = "R7";
    for (int i = 0; i < 12; i++) send((i % 3 == 0) ? 32'h55aa55aa : 32'h64636261, POS_W'(200 + i));
    drain();
    rmode = 0;

    // R7: full stall holds output and blocks input
    rmode = 2; tag = "R7";
    send(32'h0badcafe, 16'd300);
    idle(0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #3;
      check(out_valid && !in_ready, "R7 stall hold", {out_valid, in_ready}, 2'b10);
    end
    rmode = 0;
    drain();

    // R9: idle gaps between same-index items
    tag = "R9";
    for (int i = 0; i < 5; i++) begin
      send(32'h0badcafe, POS_W'(400 + i));
      idle(i + 1);
    end
    drain();

    // R1: sweep of distinct words
    tag = "R1";
    for (int i = 0; i < 24; i++) send(32'h01000193 * (i + 1) ^ 32'hdeadbeef, POS_W'(500 + i));
    drain();

    // R5: reset mid-run empties the buckets
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    model_clear();
    tag = "R5";
    send(32'h64636261, 16'd900);
    send(32'h64636261, 16'd901);
    drain();

    check(q_pos.size() == 0, "R7 queue empty", 64'(q_pos.size()), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule